// File: doc/BRIEF.md
# Seconds-and-fraction timekeeper with alarm

This block keeps wall time as a seconds word plus a 15-bit sub-second fraction. It runs in the low-power 32 kHz domain and advances once per clock. All register writes arrive as strobes that have already been synchronized into that domain. Every strobe shares one write-data bus.

A control bit starts and stops counting. The counter also stays frozen until software has written the seconds word at least once, and a write of zero counts.

An alarm register holds a seconds value. When the running seconds word reaches it, a sticky alarm flag is raised, and that flag drives an interrupt request through an enable bit. Two more sticky flags share the status word: an invalid-state flag that reset sets, and a violation flag that an external pulse sets. Software clears each flag by writing a one to its bit.

Top module: `sec_timekeeper`

## Requirements
- R1: After reset the seconds and fraction words are 0, the alarm word is all ones, the run and interrupt-enable bits are 0, the status word reads 0x00000002 and the interrupt request is low.
- R2: A control write loads the run bit from write-data bit 3. While the run bit is 0 the time words hold their value.
- R3: Until the seconds word has been written once since reset, the time words do not advance, even with the run bit set. A write of value zero is enough to allow counting.
- R4: While counting, the fraction increases by one per clock. From 32767 it wraps to 0 and the seconds word increases by one on the same clock.
- R5: A write to the seconds or fraction word loads the written value at the next clock edge. On any clock with a time-word write, no increment takes place, including on a clock where the fraction would wrap.
- R6: Status bit 4 (alarm) is set on the clock after the seconds word equals the alarm word. It stays set after they differ.
- R7: An alarm word of all ones never sets the alarm flag.
- R8: A status write clears alarm (bit 4), invalid (bit 1) and violation (bit 0) for each one in write-data at that position. Zero bits leave flags unchanged. A set condition on the same clock wins over a clear.
- R9: The invalid flag is set only by reset and stays 0 once cleared.
- R10: A one on viol_in sets status bit 0 on the next clock, and it stays set until cleared.
- R11: alm_irq is high exactly when the alarm flag and the alarm interrupt enable are both set. The enable is loaded from write-data bit 4 by an enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdata | input | 32 | Shared write data |
| ctl_we | input | 1 | Control write strobe (bit 3 run) |
| ien_we | input | 1 | Interrupt-enable write strobe (bit 4) |
| sec_we | input | 1 | Seconds word write strobe |
| frac_we | input | 1 | Fraction word write strobe |
| alm_we | input | 1 | Alarm seconds write strobe |
| stat_we | input | 1 | Status write-one-to-clear strobe |
| viol_in | input | 1 | Violation event, sets status bit 0 |
| sec_q | output | 32 | Seconds word |
| frac_q | output | 15 | Fraction word |
| alm_q | output | 32 | Alarm seconds word |
| run_en_q | output | 1 | Run bit |
| alm_ie_q | output | 1 | Alarm interrupt enable |
| status_q | output | 32 | Status flags (bits 4, 1, 0) |
| alm_irq | output | 1 | Alarm interrupt request |

## Verification
A stuck or missing seed state shows up as time words that never move after the run bit is set, or that move before any seconds write. Either is visible one clock later. A wrong wrap or write-priority decision corrupts sec_q at the 32767 boundary on that same clock, so the bench places writes right on that edge. Flag faults show at status_q one clock after the match, clear or violation, and a wrong gating term shows at alm_irq at once.

// File: rtl/sec_timekeeper.sv
module sec_timekeeper #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       wdata,
  input  logic              ctl_we,
  input  logic              ien_we,
  input  logic              sec_we,
  input  logic              frac_we,
  input  logic              alm_we,
  input  logic              stat_we,
  input  logic              viol_in,
  output logic [SEC_W-1:0]  sec_q,
  output logic [FRAC_W-1:0] frac_q,
  output logic [SEC_W-1:0]  alm_q,
  output logic              run_en_q,
  output logic              alm_ie_q,
  output logic [31:0]       status_q,
  output logic              alm_irq
);
  localparam logic [FRAC_W-1:0] FRAC_MAX = '1;
  localparam logic [SEC_W-1:0]  ALM_OFF  = '1;

  logic seeded, alm_flag, nv_flag, sv_flag;
  logic counting, wrap, alm_hit;

  assign counting = run_en_q && seeded && !sec_we && !frac_we;
  assign wrap     = frac_q == FRAC_MAX;
  assign alm_hit  = (sec_q == alm_q) && (alm_q != ALM_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      frac_q <= '0;
      seeded <= 1'b0;
    end else begin
      if (sec_we) begin
        sec_q  <= wdata[SEC_W-1:0];
        seeded <= 1'b1;
      end else if (counting && wrap) begin
        sec_q <= sec_q + 1'b1;
      end
      if (frac_we)
        frac_q <= wdata[FRAC_W-1:0];
      else if (counting)
        frac_q <= wrap ? '0 : frac_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q    <= ALM_OFF;
      run_en_q <= 1'b0;
      alm_ie_q <= 1'b0;
    end else begin
      if (alm_we) alm_q    <= wdata[SEC_W-1:0];
      if (ctl_we) run_en_q <= wdata[3];
      if (ien_we) alm_ie_q <= wdata[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_flag <= 1'b0;
      nv_flag  <= 1'b1;
      sv_flag  <= 1'b0;
    end else begin
      if (alm_hit)                     alm_flag <= 1'b1;
      else if (stat_we && wdata[4])    alm_flag <= 1'b0;
      if (stat_we && wdata[1])         nv_flag  <= 1'b0;
      if (viol_in)                     sv_flag  <= 1'b1;
      else if (stat_we && wdata[0])    sv_flag  <= 1'b0;
    end
  end

  assign status_q = {27'd0, alm_flag, 2'b00, nv_flag, sv_flag};
  assign alm_irq  = alm_flag & alm_ie_q;
endmodule

// File: rtl/sec_timekeeper_chk.sv
module sec_timekeeper_chk #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       wdata,
  input logic              sec_we,
  input logic              frac_we,
  input logic              stat_we,
  input logic              viol_in,
  input logic              seeded,
  input logic              run_en_q,
  input logic [SEC_W-1:0]  sec_q,
  input logic [FRAC_W-1:0] frac_q,
  input logic [SEC_W-1:0]  alm_q,
  input logic [31:0]       status_q
);
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en_q && !sec_we && !frac_we) |=> ($stable(sec_q) && $stable(frac_q)));

  p_hold_unseeded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!seeded && !sec_we && !frac_we) |=> ($stable(sec_q) && $stable(frac_q)));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en_q && seeded && !sec_we && !frac_we && frac_q != '1)
      |=> (frac_q == FRAC_W'($past(frac_q) + 1'b1) && $stable(sec_q)));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en_q && seeded && !sec_we && !frac_we && frac_q == '1)
      |=> (frac_q == '0 && sec_q == SEC_W'($past(sec_q) + 1'b1)));

  p_sec_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_we |=> sec_q == $past(wdata[SEC_W-1:0]));

  p_frac_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_we && !sec_we) |=> (frac_q == $past(wdata[FRAC_W-1:0]) && $stable(sec_q)));

  p_alarm_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q == alm_q && alm_q != '1) |=> status_q[4]);

  p_alarm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[4] && !(stat_we && wdata[4])) |=> status_q[4]);

  p_unset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_q == '1 && !status_q[4]) |=> !status_q[4]);

  p_nv_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !status_q[1] |=> !status_q[1]);

  p_viol_r10: assert property (@(posedge clk) disable iff (!rst_n)
    viol_in |=> status_q[0]);
endmodule

bind sec_timekeeper sec_timekeeper_chk #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdata(wdata), .sec_we(sec_we), .frac_we(frac_we),
  .stat_we(stat_we), .viol_in(viol_in), .seeded(seeded), .run_en_q(run_en_q),
  .sec_q(sec_q), .frac_q(frac_q), .alm_q(alm_q), .status_q(status_q)
);

// File: tb/sec_timekeeper_test.sv
module sec_timekeeper_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] wdata = '0;
  logic ctl_we = 0, ien_we = 0, sec_we = 0, frac_we = 0, alm_we = 0, stat_we = 0, viol_in = 0;
  logic [31:0] sec_q, alm_q, status_q;
  logic [14:0] frac_q;
  logic run_en_q, alm_ie_q, alm_irq;

  sec_timekeeper uut (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .ctl_we(ctl_we), .ien_we(ien_we),
    .sec_we(sec_we), .frac_we(frac_we), .alm_we(alm_we), .stat_we(stat_we),
    .viol_in(viol_in), .sec_q(sec_q), .frac_q(frac_q), .alm_q(alm_q),
    .run_en_q(run_en_q), .alm_ie_q(alm_ie_q), .status_q(status_q), .alm_irq(alm_irq)
  );

  always #5 clk = ~clk;

  typedef struct { string req; int sel; logic [31:0] exp; } item_t;
  item_t q[$];
  event sample_ev;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [31:0] pick(int sel);
    case (sel)
      0: return sec_q;
      1: return {17'd0, frac_q};
      2: return alm_q;
      3: return {31'd0, run_en_q};
      4: return {31'd0, alm_ie_q};
      5: return status_q;
      default: return {31'd0, alm_irq};
    endcase
  endfunction

  initial begin : monitor
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = pick(it.sel);
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(string req, int sel, logic [31:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
    -> sample_ev;
    wait (q.size() == 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // 0 ctl, 1 ien, 2 sec, 3 frac, 4 alm, 5 stat
  task automatic wr(int which, logic [31:0] d);
    wdata = d;
    case (which)
      0: ctl_we = 1; 1: ien_we = 1; 2: sec_we = 1;
      3: frac_we = 1; 4: alm_we = 1; default: stat_we = 1;
    endcase
    @(negedge clk);
    {ctl_we, ien_we, sec_we, frac_we, alm_we, stat_we} = '0;
    wdata = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    idle(3);
    expect_v("R1 sec", 0, 0);
    expect_v("R1 frac", 1, 0);
    expect_v("R1 alarm", 2, 32'hFFFF_FFFF);
    expect_v("R1 run", 3, 0);
    expect_v("R1 ie", 4, 0);
    expect_v("R1 status", 5, 32'h2);
    expect_v("R1 irq", 6, 0);
    rst_n = 1'b1;
    idle(1);

    wr(0, 32'h8);
    expect_v("R2 run bit", 3, 1);
    idle(4);
    expect_v("R3 unseeded frac", 1, 0);
    expect_v("R3 unseeded sec", 0, 0);
    wr(2, 0);
    expect_v("R5 write cycle no count", 1, 0);
    idle(5);
    expect_v("R4 frac step", 1, 5);
    wr(0, 0);
    expect_v("R2 last count", 1, 6);
    idle(3);
    expect_v("R2 stopped", 1, 6);

    wr(3, 32765);
    wr(2, 100);
    expect_v("R5 frac load", 1, 32765);
    expect_v("R5 sec load", 0, 100);
    wr(0, 32'h8);
    idle(2);
    expect_v("R4 frac top", 1, 32767);
    idle(1);
    expect_v("R4 wrap frac", 1, 0);
    expect_v("R4 wrap sec", 0, 101);
    wr(3, 32767);
    wr(2, 500);
    expect_v("R5 wrap suppressed frac", 1, 32767);
    expect_v("R5 wrap suppressed sec", 0, 500);
    idle(1);
    expect_v("R4 wrap after write", 0, 501);
    wr(0, 0);

    wr(4, 600);
    expect_v("R6 no match", 5, 32'h2);
    wr(2, 600);
    expect_v("R6 not yet", 5, 32'h2);
    idle(1);
    expect_v("R6 alarm set", 5, 32'h12);
    expect_v("R11 irq masked", 6, 0);
    wr(1, 32'h10);
    expect_v("R11 irq on", 6, 1);
    wr(4, 700);
    idle(2);
    expect_v("R6 sticky", 5, 32'h12);
    wr(5, 32'h0);
    expect_v("R8 zero write", 5, 32'h12);
    wr(5, 32'h10);
    expect_v("R8 alarm cleared", 5, 32'h2);
    expect_v("R11 irq off", 6, 0);
    wr(5, 32'h2);
    expect_v("R9 invalid cleared", 5, 32'h0);
    idle(3);
    expect_v("R9 stays clear", 5, 32'h0);

    wr(4, 32'hFFFF_FFFF);
    wr(2, 32'hFFFF_FFFF);
    idle(2);
    expect_v("R7 all ones no alarm", 5, 32'h0);

    wr(4, 7);
    wr(2, 7);
    idle(1);
    expect_v("R6 alarm at 7", 5, 32'h10);
    wr(5, 32'h10);
    expect_v("R8 set wins", 5, 32'h10);

    viol_in = 1'b1;
    idle(1);
    viol_in = 1'b0;
    expect_v("R10 viol set", 5, 32'h11);
    idle(2);
    expect_v("R10 viol sticky", 5, 32'h11);
    wr(5, 32'h1);
    expect_v("R8 viol cleared", 5, 32'h10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule